// File: doc/BRIEF.md
# Write-Only Bus Target with Disconnect Control

This block is the target side of a 32-bit multiplexed address/data parallel bus, limited to write transactions. It watches for the start of an address phase, and it claims the transaction when the external address decoder reports a hit and the command is a write. To claim it, the block pulls its device-select line low. Each completed data phase goes to the back-end as a registered strobe, together with the data word and the active byte lanes.

The back-end controls the bus through two active-low inputs: a ready request and a stop request. Each one reaches the bus with exactly one registered cycle of lag. To end a burst early, the back-end drops ready and raises the stop request in the same cycle. The block then holds stop low until the initiator removes frame. It releases device-select and stop on the following edge, drives all three control lines high for one turnaround cycle, and then turns its output enable off.

Top module: `pci_wr_target`

## Requirements
- R1: An address phase is a rising clock edge where `frame_n` is sampled low after it was high on the previous edge. When an address phase arrives in idle with `addr_hit` high and `cbe_n[0]` = 1 (the write encoding), the block reacts after that edge. `devsel_n` goes low, `ctl_oe` goes high, and `be_addr_valid` pulses high for exactly one cycle. `be_addr` and `be_cmd` hold the sampled `ad_in` and `cbe_n`.
- R2: An address phase with `addr_hit` low, or with `cbe_n[0]` = 0 (a read), is not claimed. `ctl_oe` stays low and `be_addr_valid` stays low.
- R3: While the block holds the claim and no stop is pending, `trdy_n` takes on the value that `be_ready_n` had at the previous clock edge.
- R4: `stop_n` goes low on the edge after `be_disc_n` is sampled low, and it stays low until the release.
- R5: A data phase completes on an edge where `irdy_n`, `trdy_n` and `devsel_n` are all low. After that edge, `be_xfer_n` is low for one cycle, `be_data` holds the sampled `ad_in`, and `be_byte_en` holds the inverse of the sampled `cbe_n` (1 = lane enabled).
- R6: While `irdy_n` is high, no data phase completes and `be_xfer_n` stays high, even with `trdy_n` low.
- R7: After stop is asserted, the block keeps `devsel_n` and `stop_n` low while `frame_n` is sampled low. On the first edge where `frame_n` is sampled high, both go high.
- R8: Without a stop, the release happens on the edge where a data phase completes with `frame_n` sampled high. That edge sets `devsel_n` and `trdy_n` high.
- R9: After any release, all three control lines stay driven high with `ctl_oe` high for exactly one cycle. Then `ctl_oe` goes low.
- R10: An address phase that arrives while the block is not idle is ignored. This includes the turnaround cycle. It causes no claim and leaves `be_addr` unchanged.
- R11: After the synchronous active-high reset, `devsel_n`, `trdy_n`, `stop_n` and `be_xfer_n` are high, and `ctl_oe` and `be_addr_valid` are low.
- R12: `be_is_write` equals bit 0 of the captured command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_n | input | 1 | Initiator frame, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| ad_in | input | DATA_W | Multiplexed address/data lines |
| cbe_n | input | DATA_W/8 | Command / byte-enable lines, active low enables |
| addr_hit | input | 1 | External address decoder hit |
| devsel_n | output | 1 | Device select, active low, registered |
| trdy_n | output | 1 | Target ready, active low, registered |
| stop_n | output | 1 | Target stop, active low, registered |
| ctl_oe | output | 1 | Output enable for the three control lines |
| be_ready_n | input | 1 | Back-end ready request, active low |
| be_disc_n | input | 1 | Back-end stop request, active low |
| be_addr_valid | output | 1 | One-cycle pulse when a claim is made |
| be_addr | output | DATA_W | Captured address |
| be_cmd | output | DATA_W/8 | Captured command |
| be_is_write | output | 1 | Direction flag from the captured command |
| be_xfer_n | output | 1 | Data-phase completion strobe, active low |
| be_data | output | DATA_W | Data word of the completed phase |
| be_byte_en | output | DATA_W/8 | Byte lanes of the completed phase, 1 = enabled |

## Verification
The bench builds the block with its defaults: a 32-bit data path and four command/byte-enable lines, so every command encoding and byte-lane pattern on the real bus can be reached. These directed scenarios exercise:
- the claim and the cases that are not claimed;
- an initiator wait state;
- a multi-phase burst that ends normally;
- a stop that leaves data behind;
- a stop with frame held low for extra cycles;
- an address phase placed in the turnaround cycle.

// File: rtl/pci_wr_pkg.sv
package pci_wr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CLAIM = 3'd1,
    ST_DATA  = 3'd2,
    ST_DISC  = 3'd3,
    ST_TURN  = 3'd4
  } tgt_state_t;

  // bit of the command nibble that marks a write
  localparam int WRITE_BIT = 0;
endpackage

// File: rtl/pci_wr_addr_dec.sv
module pci_wr_addr_dec #(
  parameter int DATA_W = 32,
  parameter int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_n,
  input  logic [DATA_W-1:0] ad_in,
  input  logic [BE_W-1:0]   cbe_n,
  input  logic              addr_hit,
  input  logic              idle,
  output logic              claim,
  output logic              addr_valid,
  output logic [DATA_W-1:0] addr_q,
  output logic [BE_W-1:0]   cmd_q,
  output logic              is_write
);
  import pci_wr_pkg::*;

  logic frame_q;
  logic addr_phase;

  assign addr_phase = frame_q && !frame_n;
  assign claim      = idle && addr_phase && addr_hit && cbe_n[WRITE_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q    <= 1'b1;
      addr_valid <= 1'b0;
      addr_q     <= '0;
      cmd_q      <= '0;
    end else begin
      frame_q    <= frame_n;
      addr_valid <= claim;
      if (claim) begin
        addr_q <= ad_in;
        cmd_q  <= cbe_n;
      end
    end
  end

  assign is_write = cmd_q[WRITE_BIT];
endmodule

// File: rtl/pci_wr_fsm.sv
module pci_wr_fsm (
  input  logic clk,
  input  logic rst,
  input  logic claim,
  input  logic frame_n,
  input  logic irdy_n,
  input  logic be_ready_n,
  input  logic be_disc_n,
  output logic devsel_n,
  output logic trdy_n,
  output logic stop_n,
  output logic ctl_oe,
  output logic idle,
  output logic phase_done
);
  import pci_wr_pkg::*;

  tgt_state_t state;

  assign idle       = (state == ST_IDLE);
  assign phase_done = !idle && (state != ST_TURN) && !devsel_n && !trdy_n && !irdy_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      devsel_n <= 1'b1;
      trdy_n   <= 1'b1;
      stop_n   <= 1'b1;
      ctl_oe   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (claim) begin
            state    <= ST_CLAIM;
            devsel_n <= 1'b0;
            trdy_n   <= 1'b1;
            stop_n   <= 1'b1;
            ctl_oe   <= 1'b1;
          end
        end
        ST_CLAIM, ST_DATA: begin
          if (phase_done && frame_n) begin
            state    <= ST_TURN;
            devsel_n <= 1'b1;
            trdy_n   <= 1'b1;
            stop_n   <= 1'b1;
          end else begin
            trdy_n <= be_ready_n;
            stop_n <= be_disc_n;
            state  <= be_disc_n ? ST_DATA : ST_DISC;
          end
        end
        ST_DISC: begin
          trdy_n <= 1'b1;
          if (frame_n) begin
            state    <= ST_TURN;
            devsel_n <= 1'b1;
            stop_n   <= 1'b1;
          end
        end
        ST_TURN: begin
          ctl_oe <= 1'b0;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pci_wr_sink.sv
module pci_wr_sink #(
  parameter int DATA_W = 32,
  parameter int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              phase_done,
  input  logic [DATA_W-1:0] ad_in,
  input  logic [BE_W-1:0]   cbe_n,
  output logic              xfer_n,
  output logic [DATA_W-1:0] data_q,
  output logic [BE_W-1:0]   byte_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      xfer_n  <= 1'b1;
      data_q  <= '0;
      byte_en <= '0;
    end else begin
      xfer_n <= !phase_done;
      if (phase_done) begin
        data_q <= ad_in;
      end
    end
  end

  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) byte_en[g] <= 1'b0;
      else if (phase_done) byte_en[g] <= !cbe_n[g];
    end
  end
endmodule

// File: rtl/pci_wr_target.sv
module pci_wr_target #(
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic [DATA_W-1:0] ad_in,
  input  logic [BE_W-1:0]   cbe_n,
  input  logic              addr_hit,
  output logic              devsel_n,
  output logic              trdy_n,
  output logic              stop_n,
  output logic              ctl_oe,
  input  logic              be_ready_n,
  input  logic              be_disc_n,
  output logic              be_addr_valid,
  output logic [DATA_W-1:0] be_addr,
  output logic [BE_W-1:0]   be_cmd,
  output logic              be_is_write,
  output logic              be_xfer_n,
  output logic [DATA_W-1:0] be_data,
  output logic [BE_W-1:0]   be_byte_en
);
  logic claim;
  logic idle;
  logic phase_done;

  pci_wr_addr_dec #(.DATA_W(DATA_W), .BE_W(BE_W)) u_addr (
    .clk        (clk),
    .rst        (rst),
    .frame_n    (frame_n),
    .ad_in      (ad_in),
    .cbe_n      (cbe_n),
    .addr_hit   (addr_hit),
    .idle       (idle),
    .claim      (claim),
    .addr_valid (be_addr_valid),
    .addr_q     (be_addr),
    .cmd_q      (be_cmd),
    .is_write   (be_is_write)
  );

  pci_wr_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .claim      (claim),
    .frame_n    (frame_n),
    .irdy_n     (irdy_n),
    .be_ready_n (be_ready_n),
    .be_disc_n  (be_disc_n),
    .devsel_n   (devsel_n),
    .trdy_n     (trdy_n),
    .stop_n     (stop_n),
    .ctl_oe     (ctl_oe),
    .idle       (idle),
    .phase_done (phase_done)
  );

  pci_wr_sink #(.DATA_W(DATA_W), .BE_W(BE_W)) u_sink (
    .clk        (clk),
    .rst        (rst),
    .phase_done (phase_done),
    .ad_in      (ad_in),
    .cbe_n      (cbe_n),
    .xfer_n     (be_xfer_n),
    .data_q     (be_data),
    .byte_en    (be_byte_en)
  );
endmodule

// File: rtl/pci_wr_target_chk.sv
module pci_wr_target_chk (
  input logic clk,
  input logic rst,
  input logic frame_n,
  input logic irdy_n,
  input logic devsel_n,
  input logic trdy_n,
  input logic stop_n,
  input logic ctl_oe,
  input logic be_ready_n,
  input logic be_disc_n,
  input logic be_addr_valid,
  input logic be_xfer_n
);
  assert_claim_R1: assert property (@(posedge clk) disable iff (rst)
    be_addr_valid |-> (!devsel_n && ctl_oe));

  assert_trdy_lag_R3: assert property (@(posedge clk) disable iff (rst)
    !trdy_n |-> $past(!be_ready_n));

  assert_stop_lag_R4: assert property (@(posedge clk) disable iff (rst)
    !stop_n |-> ($past(!be_disc_n) || $past(!stop_n)));

  assert_xfer_R5: assert property (@(posedge clk) disable iff (rst)
    !be_xfer_n |-> $past(!irdy_n && !trdy_n && !devsel_n));

  assert_release_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(devsel_n) |-> $past(frame_n));

  assert_turn_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(ctl_oe) |-> ($past(devsel_n) && $past(trdy_n) && $past(stop_n)));

  assert_idle_high_R11: assert property (@(posedge clk) disable iff (rst)
    !ctl_oe |-> (devsel_n && trdy_n && stop_n));
endmodule

bind pci_wr_target pci_wr_target_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .frame_n       (frame_n),
  .irdy_n        (irdy_n),
  .devsel_n      (devsel_n),
  .trdy_n        (trdy_n),
  .stop_n        (stop_n),
  .ctl_oe        (ctl_oe),
  .be_ready_n    (be_ready_n),
  .be_disc_n     (be_disc_n),
  .be_addr_valid (be_addr_valid),
  .be_xfer_n     (be_xfer_n)
);

// File: tb/test_pci_wr_target.sv
module test_pci_wr_target;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_n = 1'b1, irdy_n = 1'b1, addr_hit = 1'b0;
  logic [31:0] ad_in = '0;
  logic [3:0]  cbe_n = 4'hF;
  logic        be_ready_n = 1'b1, be_disc_n = 1'b1;
  logic        devsel_n, trdy_n, stop_n, ctl_oe;
  logic        be_addr_valid, be_is_write, be_xfer_n;
  logic [31:0] be_addr, be_data;
  logic [3:0]  be_cmd, be_byte_en;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  pci_wr_target i_pci_wr_target (
    .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .ad_in(ad_in),
    .cbe_n(cbe_n), .addr_hit(addr_hit), .devsel_n(devsel_n), .trdy_n(trdy_n),
    .stop_n(stop_n), .ctl_oe(ctl_oe), .be_ready_n(be_ready_n),
    .be_disc_n(be_disc_n), .be_addr_valid(be_addr_valid), .be_addr(be_addr),
    .be_cmd(be_cmd), .be_is_write(be_is_write), .be_xfer_n(be_xfer_n),
    .be_data(be_data), .be_byte_en(be_byte_en)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic bus_idle();
    frame_n = 1'b1; irdy_n = 1'b1; addr_hit = 1'b0; cbe_n = 4'hF;
    be_ready_n = 1'b1; be_disc_n = 1'b1; ad_in = '0;
    step(); step();
  endtask

  task automatic t_reset();
    chk("R11", "devsel_n", devsel_n, 1);
    chk("R11", "trdy_n", trdy_n, 1);
    chk("R11", "stop_n", stop_n, 1);
    chk("R11", "ctl_oe", ctl_oe, 0);
    chk("R11", "be_xfer_n", be_xfer_n, 1);
    chk("R11", "be_addr_valid", be_addr_valid, 0);
  endtask

  // stop after one data word, frame drops at once; new address in turnaround
  task automatic t_disc_with_word();
    frame_n = 1'b0; ad_in = 32'h1000_0040; cbe_n = 4'b0111; addr_hit = 1'b1;
    step();
    chk("R1", "devsel_n", devsel_n, 0);
    chk("R1", "ctl_oe", ctl_oe, 1);
    chk("R1", "addr_valid", be_addr_valid, 1);
    chk("R1", "be_addr", be_addr, 32'h1000_0040);
    chk("R1", "be_cmd", be_cmd, 4'b0111);
    chk("R12", "is_write", be_is_write, 1);
    chk("R3", "trdy_n before ready", trdy_n, 1);
    addr_hit = 1'b0; ad_in = 32'hCAFE_0001; cbe_n = 4'b0000; irdy_n = 1'b0; be_ready_n = 1'b0;
    step();
    chk("R1", "addr_valid one cycle", be_addr_valid, 0);
    chk("R3", "trdy_n follows ready", trdy_n, 0);
    chk("R5", "no xfer yet", be_xfer_n, 1);
    be_ready_n = 1'b1; be_disc_n = 1'b0;
    step();
    chk("R5", "xfer strobe", be_xfer_n, 0);
    chk("R5", "data", be_data, 32'hCAFE_0001);
    chk("R5", "byte_en", be_byte_en, 4'hF);
    chk("R3", "trdy_n released", trdy_n, 1);
    chk("R4", "stop_n", stop_n, 0);
    frame_n = 1'b1; be_disc_n = 1'b1; ad_in = 32'hCAFE_0002;
    step();
    chk("R7", "devsel_n released", devsel_n, 1);
    chk("R7", "stop_n released", stop_n, 1);
    chk("R9", "oe held in turn", ctl_oe, 1);
    chk("R5", "strobe one cycle", be_xfer_n, 1);
    irdy_n = 1'b1; frame_n = 1'b0; ad_in = 32'h2000_0000; cbe_n = 4'b0111; addr_hit = 1'b1;
    step();
    chk("R9", "oe off after turn", ctl_oe, 0);
    chk("R10", "no claim in turn", be_addr_valid, 0);
    chk("R10", "addr kept", be_addr, 32'h1000_0040);
    bus_idle();
    chk("R10", "still idle", ctl_oe, 0);
  endtask

  // initiator wait state, two words, normal completion
  task automatic t_burst_wait();
    frame_n = 1'b0; ad_in = 32'h0000_0100; cbe_n = 4'b1111; addr_hit = 1'b1;
    step();
    chk("R1", "claim burst", devsel_n, 0);
    chk("R12", "is_write cmd F", be_is_write, 1);
    addr_hit = 1'b0; be_ready_n = 1'b0; irdy_n = 1'b1; ad_in = 32'h1111_1111; cbe_n = 4'b1010;
    step();
    chk("R3", "trdy_n low", trdy_n, 0);
    step();
    chk("R6", "irdy high no xfer", be_xfer_n, 1);
    irdy_n = 1'b0;
    step();
    chk("R5", "word1 strobe", be_xfer_n, 0);
    chk("R5", "word1 data", be_data, 32'h1111_1111);
    chk("R5", "word1 lanes", be_byte_en, 4'b0101);
    frame_n = 1'b1; ad_in = 32'h2222_2222; cbe_n = 4'b0011;
    step();
    chk("R5", "word2 strobe", be_xfer_n, 0);
    chk("R5", "word2 data", be_data, 32'h2222_2222);
    chk("R5", "word2 lanes", be_byte_en, 4'b1100);
    chk("R8", "devsel_n released", devsel_n, 1);
    chk("R8", "trdy_n released", trdy_n, 1);
    chk("R9", "oe held", ctl_oe, 1);
    irdy_n = 1'b1; be_ready_n = 1'b1;
    step();
    chk("R9", "oe off", ctl_oe, 0);
    bus_idle();
  endtask

  // stop without data, frame held low two extra cycles
  task automatic t_disc_no_data();
    frame_n = 1'b0; ad_in = 32'h0000_0200; cbe_n = 4'b0111; addr_hit = 1'b1;
    step();
    addr_hit = 1'b0; irdy_n = 1'b0; be_disc_n = 1'b0; cbe_n = 4'b0000; ad_in = 32'hDEAD_BEEF;
    step();
    chk("R4", "stop_n low", stop_n, 0);
    chk("R3", "trdy_n high", trdy_n, 1);
    be_disc_n = 1'b1;
    step();
    chk("R7", "stop held", stop_n, 0);
    chk("R7", "devsel held", devsel_n, 0);
    chk("R6", "no xfer", be_xfer_n, 1);
    frame_n = 1'b1;
    step();
    chk("R7", "devsel released", devsel_n, 1);
    chk("R7", "stop released", stop_n, 1);
    chk("R5", "no xfer on stop", be_xfer_n, 1);
    irdy_n = 1'b1;
    step();
    chk("R9", "oe off", ctl_oe, 0);
    bus_idle();
  endtask

  // decoder miss and read command are not claimed
  task automatic t_no_claim();
    frame_n = 1'b0; ad_in = 32'h0000_0300; cbe_n = 4'b0111; addr_hit = 1'b0;
    step();
    chk("R2", "miss oe", ctl_oe, 0);
    chk("R2", "miss valid", be_addr_valid, 0);
    frame_n = 1'b1;
    step();
    frame_n = 1'b0; cbe_n = 4'b0110; addr_hit = 1'b1;
    step();
    chk("R2", "read oe", ctl_oe, 0);
    chk("R2", "read devsel", devsel_n, 1);
    chk("R2", "read valid", be_addr_valid, 0);
    bus_idle();
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    t_reset();
    t_disc_with_word();
    t_burst_wait();
    t_disc_no_data();
    t_no_claim();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule